// File: doc/BRIEF.md
# Downstream Port Status and Control Register

This block holds the state of one downstream port of a USB host root hub and presents it as a single 32-bit register. A read returns the port's live condition: device attached, port enabled, port suspended, over-current present, bus reset in progress, power applied and low-speed device present. The same word also carries five latched change flags.

A write does not load the fields directly. Each bit position acts as a command whose meaning differs from the value read back at that position. A 1 in a command bit fires that command, and a 0 does nothing. The change flags are cleared by writing 1 to them.

The block samples the physical port signals: device present, low-speed indication, over-current level and a reset-completion pulse. It drives the enable, suspend, reset and power controls of the port transceiver. The timing of bus reset and resume signalling happens outside the block. The block only sees the end of a bus reset, as a one-cycle completion pulse.

Top module: `rh_port_reg`

## Requirements
- R1: After a synchronous active-low reset, rd_data reads 0 and the enable, suspend, reset and power outputs are all 0 (with no device present).
- R2: Bit 0 of rd_data shows dev_present one clock after it is sampled. Every change of that bit sets the connect-change flag at bit 16.
- R3: Writing 1 to bit 1 enables the port when a device is connected and power is on. If no device is connected, the port stays disabled and the connect-change flag (bit 16) is set instead.
- R4: Writing 1 to bit 0 disables the port and also drops suspend.
- R5: Writing 1 to bit 2 suspends an enabled port (read at bit 2). On a disabled port it has no effect. Writing 1 to bit 3 ends a suspend and sets the suspend-change flag at bit 18.
- R6: Writing 1 to bit 4 starts a port reset (read at bit 4 and on port_reset_o) when a device is connected and power is on. A reset_done pulse ends it, enables the port and sets the reset-change flag at bit 20.
- R7: Writing 1 to bit 8 turns port power on (read at bit 8). Writing 1 to bit 9 turns it off, which clears enable, suspend and reset without setting the enable-change flag.
- R8: Bit 3 reads the sampled over-current level. Its rising edge sets the over-current-change flag at bit 19 and removes port power. If the port was enabled, that edge also sets the enable-change flag at bit 17.
- R9: Bit 9 reads 1 only while a device is connected and the sampled low-speed input is 1.
- R10: Writing 1 to any of bits 20:16 clears the matching change flag. Flags written with 0 keep their value.
- R11: A write of all zeros changes no register state.
- R12: When a device detaches, enable, suspend and reset drop, and both the connect-change (bit 16) and enable-change (bit 17) flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write command word |
| rd_data | output | 32 | Current register value |
| dev_present | input | 1 | Device attached on the port |
| dev_low_speed | input | 1 | Attached device is low speed |
| oc_in | input | 1 | Over-current level from the port |
| reset_done | input | 1 | One-cycle pulse: bus reset signalling finished |
| port_enable_o | output | 1 | Port enable control |
| port_suspend_o | output | 1 | Port suspend control |
| port_reset_o | output | 1 | Drive bus reset on the port |
| port_power_o | output | 1 | Port power switch |

## Verification
The assertions assume that reset_done arrives as a one-cycle pulse. They also assume that the physical inputs are synchronous to clk, so a detach or over-current edge is seen at one defined edge. The bench drives every input on the falling edge, holds each event level for several cycles, and pulses reset_done only while a port reset is pending. This way each transition is handled by itself, apart from the priorities the requirements describe.

// File: rtl/rhp_pkg.sv
// Package: shared bit positions and the decoded command type for the
// root hub port register. Assumes a 32-bit register word.
package rhp_pkg;
    localparam int REG_W   = 32;
    // read/command bit positions (software decodes these)
    localparam int B_CCS   = 0;
    localparam int B_PES   = 1;
    localparam int B_PSS   = 2;
    localparam int B_POC   = 3;
    localparam int B_PRS   = 4;
    localparam int B_PPS   = 8;
    localparam int B_LSA   = 9;
    // change flags
    localparam int C_BASE  = 16;
    localparam int NCHG    = 5;
    localparam int CH_CONN = 0;
    localparam int CH_EN   = 1;
    localparam int CH_SUSP = 2;
    localparam int CH_OC   = 3;
    localparam int CH_RST  = 4;

    typedef struct packed {
        logic            clr_en;
        logic            set_en;
        logic            set_susp;
        logic            clr_susp;
        logic            set_rst;
        logic            set_pwr;
        logic            clr_pwr;
        logic [NCHG-1:0] chg_clr;
    } port_cmd_t;
endpackage

// File: rtl/rhp_wr_decode.sv
// Module: turns one register write into command pulses.
// Assumes wr_en is a single-cycle strobe. A 0 bit never yields a command.
module rhp_wr_decode
    import rhp_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output port_cmd_t        cmd
);
    // decode each command bit, gated by the strobe
    always_comb begin
        cmd          = '0;
        cmd.clr_en   = wr_en & wr_data[B_CCS];
        cmd.set_en   = wr_en & wr_data[B_PES];
        cmd.set_susp = wr_en & wr_data[B_PSS];
        cmd.clr_susp = wr_en & wr_data[B_POC];
        cmd.set_rst  = wr_en & wr_data[B_PRS];
        cmd.set_pwr  = wr_en & wr_data[B_PPS];
        cmd.clr_pwr  = wr_en & wr_data[B_LSA];
        cmd.chg_clr  = wr_en ? wr_data[C_BASE +: NCHG] : '0;
    end
endmodule

// File: rtl/rhp_port_fsm.sv
// Module: port state (connect, enable, suspend, reset, power, over-current,
// low speed) and the change events it raises.
// Assumes physical inputs are synchronous to clk and reset_done is a pulse.
// Priority: power removal, then detach, then reset completion, then writes.
module rhp_port_fsm
    import rhp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  port_cmd_t       cmd,
    input  logic            dev_present,
    input  logic            dev_low_speed,
    input  logic            oc_in,
    input  logic            reset_done,
    output logic            ccs_o,
    output logic            en_o,
    output logic            susp_o,
    output logic            rst_o,
    output logic            pwr_o,
    output logic            oc_o,
    output logic            ls_o,
    output logic [NCHG-1:0] chg_set
);
    logic ccs_q, en_q, susp_q, rst_q, pwr_q, oc_q, ls_q;
    logic en_d, susp_d, rst_d, pwr_d;
    logic oc_rise, detach, pwr_off, kill, set_en_ok;

    // event detection on sampled inputs
    always_comb begin
        oc_rise   = oc_in & ~oc_q;
        detach    = ccs_q & ~dev_present;
        pwr_off   = oc_rise | cmd.clr_pwr;
        kill      = pwr_off | detach;
        set_en_ok = cmd.set_en & ccs_q & pwr_q;
    end

    // next-state for power, enable, suspend and reset
    always_comb begin
        pwr_d  = pwr_off ? 1'b0 : (cmd.set_pwr ? 1'b1 : pwr_q);
        en_d   = en_q;
        susp_d = susp_q;
        rst_d  = rst_q;
        if (kill) begin
            en_d   = 1'b0;
            susp_d = 1'b0;
            rst_d  = 1'b0;
        end else begin
            if (rst_q && reset_done) begin
                rst_d = 1'b0;
                en_d  = 1'b1;
            end else if (cmd.set_rst && ccs_q && pwr_q) begin
                rst_d = 1'b1;
            end
            if (cmd.clr_en) begin
                en_d   = 1'b0;
                susp_d = 1'b0;
            end else if (set_en_ok) begin
                en_d = 1'b1;
            end
            if (cmd.clr_susp && susp_q) begin
                susp_d = 1'b0;
            end else if (cmd.set_susp && en_q && !cmd.clr_en) begin
                susp_d = 1'b1;
            end
        end
    end

    // change events raised this cycle
    always_comb begin
        chg_set          = '0;
        chg_set[CH_CONN] = (ccs_q != dev_present) | (cmd.set_en & ~ccs_q);
        chg_set[CH_EN]   = en_q & (oc_rise | detach);
        chg_set[CH_SUSP] = cmd.clr_susp & susp_q & ~kill;
        chg_set[CH_OC]   = oc_rise;
        chg_set[CH_RST]  = rst_q & reset_done & ~kill;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccs_q  <= 1'b0;
            en_q   <= 1'b0;
            susp_q <= 1'b0;
            rst_q  <= 1'b0;
            pwr_q  <= 1'b0;
            oc_q   <= 1'b0;
            ls_q   <= 1'b0;
        end else begin
            ccs_q  <= dev_present;
            en_q   <= en_d;
            susp_q <= susp_d;
            rst_q  <= rst_d;
            pwr_q  <= pwr_d;
            oc_q   <= oc_in;
            ls_q   <= dev_low_speed;
        end
    end

    assign ccs_o  = ccs_q;
    assign en_o   = en_q;
    assign susp_o = susp_q;
    assign rst_o  = rst_q;
    assign pwr_o  = pwr_q;
    assign oc_o   = oc_q;
    assign ls_o   = ccs_q & ls_q;

    AST_EN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n) en_q |-> pwr_q); // R7
    AST_SUSP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) susp_q |-> en_q); // R5
    AST_RST_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n) rst_q |-> pwr_q); // R6
    AST_OC_CUTS_PWR: assert property (@(posedge clk) disable iff (!rst_n) (oc_in && !oc_q) |=> !pwr_q); // R8
    AST_RST_DONE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q && reset_done && !oc_rise && !cmd.clr_pwr && !detach && !cmd.clr_en) |=> (en_q && !rst_q)); // R6
    AST_DETACH_DISABLES: assert property (@(posedge clk) disable iff (!rst_n) (ccs_q && !dev_present) |=> (!en_q && !susp_q)); // R12
endmodule

// File: rtl/rhp_chg_flags.sv
// Module: bank of latched change flags, set by hardware events and cleared
// by writing 1. A set event in the same cycle as a clear wins.
module rhp_chg_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flg_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // one sticky flag: set has priority over a write-one clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flg_q[i] <= 1'b0;
            else if (set_i[i])   flg_q[i] <= 1'b1;
            else if (clr_i[i])   flg_q[i] <= 1'b0;
        end

        AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n) set_i[i] |=> flg_q[i]); // R2
        AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n) (clr_i[i] && !set_i[i]) |=> !flg_q[i]); // R10
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!clr_i[i] && flg_q[i]) |=> flg_q[i]); // R10
    end

    assign flags_o = flg_q;
endmodule

// File: rtl/rh_port_reg.sv
// Module: top of the root hub port register. Decodes write commands, keeps
// port state and change flags, and assembles the read word.
// Assumes one register access per cycle and inputs synchronous to clk.
module rh_port_reg
    import rhp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             dev_present,
    input  logic             dev_low_speed,
    input  logic             oc_in,
    input  logic             reset_done,
    output logic             port_enable_o,
    output logic             port_suspend_o,
    output logic             port_reset_o,
    output logic             port_power_o
);
    port_cmd_t       cmd;
    logic            ccs, en, susp, rst, pwr, oc, ls;
    logic [NCHG-1:0] chg_set, chg_flags;

    rhp_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    rhp_port_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .dev_present   (dev_present),
        .dev_low_speed (dev_low_speed),
        .oc_in         (oc_in),
        .reset_done    (reset_done),
        .ccs_o         (ccs),
        .en_o          (en),
        .susp_o        (susp),
        .rst_o         (rst),
        .pwr_o         (pwr),
        .oc_o          (oc),
        .ls_o          (ls),
        .chg_set       (chg_set)
    );

    rhp_chg_flags #(.N(NCHG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (chg_set),
        .clr_i   (cmd.chg_clr),
        .flags_o (chg_flags)
    );

    // assemble the read word from state and flags
    always_comb begin
        rd_data                 = '0;
        rd_data[B_CCS]          = ccs;
        rd_data[B_PES]          = en;
        rd_data[B_PSS]          = susp;
        rd_data[B_POC]          = oc;
        rd_data[B_PRS]          = rst;
        rd_data[B_PPS]          = pwr;
        rd_data[B_LSA]          = ls;
        rd_data[C_BASE +: NCHG] = chg_flags;
    end

    assign port_enable_o  = en;
    assign port_suspend_o = susp;
    assign port_reset_o   = rst;
    assign port_power_o   = pwr;

    AST_ZERO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0 && !reset_done && oc_in == oc && dev_present == ccs)
        |=> $stable({port_enable_o, port_suspend_o, port_reset_o, port_power_o})); // R11
endmodule

// File: tb/test_rh_port_reg.sv
module test_rh_port_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dev_present = 1'b0;
    logic        dev_low_speed = 1'b0;
    logic        oc_in = 1'b0;
    logic        reset_done = 1'b0;
    logic        port_enable_o, port_suspend_o, port_reset_o, port_power_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rh_port_reg i_rh_port_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .dev_present(dev_present),
        .dev_low_speed(dev_low_speed), .oc_in(oc_in), .reset_done(reset_done),
        .port_enable_o(port_enable_o), .port_suspend_o(port_suspend_o),
        .port_reset_o(port_reset_o), .port_power_o(port_power_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // write for one cycle; returns at the falling edge after the update
    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 rd", rd_data, 32'h0);
        chk("R1 outs", {28'h0, port_enable_o, port_suspend_o, port_reset_o, port_power_o}, 32'h0);
    endtask

    task automatic t_power_and_nodev();
        wr(32'h100);
        chk("R7 power on", rd_data, 32'h100);
        chk("R7 power pin", {31'h0, port_power_o}, 32'h1);
        wr(32'h2);
        chk("R3 enable no device", rd_data, 32'h10100);
        chk("R3 enable pin", {31'h0, port_enable_o}, 32'h0);
        wr(32'h10000);
        chk("R10 clear conn chg", rd_data, 32'h100);
    endtask

    task automatic t_attach();
        @(negedge clk); dev_present = 1'b1; dev_low_speed = 1'b1;
        @(negedge clk);
        chk("R2 R9 attach", rd_data, 32'h10301);
        wr(32'h10000);
        chk("R10 clear", rd_data, 32'h301);
        wr(32'h0);
        chk("R11 zero write", rd_data, 32'h301);
    endtask

    task automatic t_port_reset();
        wr(32'h10);
        chk("R6 reset start", rd_data, 32'h311);
        chk("R6 reset pin", {31'h0, port_reset_o}, 32'h1);
        @(negedge clk); reset_done = 1'b1;
        @(negedge clk); reset_done = 1'b0;
        chk("R6 reset done", rd_data, 32'h100303);
        wr(32'h100000);
        chk("R10 clear rst chg", rd_data, 32'h303);
    endtask

    task automatic t_suspend();
        wr(32'h4);
        chk("R5 suspend", rd_data, 32'h307);
        chk("R5 suspend pin", {31'h0, port_suspend_o}, 32'h1);
        wr(32'h8);
        chk("R5 resume", rd_data, 32'h40303);
        wr(32'h40000);
        chk("R10 clear susp chg", rd_data, 32'h303);
    endtask

    task automatic t_disable();
        wr(32'h1);
        chk("R4 disable", rd_data, 32'h301);
        wr(32'h4);
        chk("R5 suspend when disabled", rd_data, 32'h301);
        wr(32'h2);
        chk("R3 enable", rd_data, 32'h303);
    endtask

    task automatic t_power_off();
        wr(32'h4);
        chk("R7 pre", rd_data, 32'h307);
        wr(32'h200);
        chk("R7 power off", rd_data, 32'h201);
        chk("R7 pins", {28'h0, port_enable_o, port_suspend_o, port_reset_o, port_power_o}, 32'h0);
        wr(32'h100);
        wr(32'h2);
        chk("R7 restore", rd_data, 32'h303);
    endtask

    task automatic t_overcurrent();
        @(negedge clk); oc_in = 1'b1;
        @(negedge clk);
        chk("R8 oc edge", rd_data, 32'hA0209);
        chk("R8 power pin", {31'h0, port_power_o}, 32'h0);
        oc_in = 1'b0;
        @(negedge clk);
        chk("R8 oc level", rd_data, 32'hA0201);
        wr(32'hA0000);
        chk("R10 clear oc en", rd_data, 32'h201);
    endtask

    task automatic t_detach();
        wr(32'h100); wr(32'h2); wr(32'h4);
        chk("R12 pre", rd_data, 32'h307);
        @(negedge clk); dev_present = 1'b0;
        @(negedge clk);
        chk("R12 R9 detach", rd_data, 32'h30100);
        chk("R12 pins", {28'h0, port_enable_o, port_suspend_o, port_reset_o, port_power_o}, 32'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_power_and_nodev();
        t_attach();
        t_port_reset();
        t_suspend();
        t_disable();
        t_power_off();
        t_overcurrent();
        t_detach();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule